// File: doc/BRIEF.md
# Tensor Instruction Sequencer

This block is the front end of a matrix accelerator. A host pushes 96-bit instructions into it as three 32-bit words. Each complete instruction goes into a small in-order buffer. The sequencer takes instructions from that buffer one at a time, decodes them, and turns each one into a run of commands for one of four execution units: the host-transfer engine, the weight loader, the matrix unit and the activation stage. An instruction's repeat field sets how many times its command is issued.

The sequencer works on a decoupled access/execute model. A weight-read instruction retires as soon as the weight loader accepts its command, and the sequencer keeps a count of staged weight tiles, at most four. A matrix command is presented only when three conditions hold: a tile is staged, weight data is reported available, and input activations are reported available. Each accepted matrix command uses up one staged tile. Once a matrix command has been handed off, later instructions continue to issue while the matrix unit is still busy. Only a sync instruction, or a halt, waits for every unit to report idle.

The pipeline has four stages: word assembly, the instruction buffer, the decode register, and the issue state machine. The state machine has five states:
- ST_FETCH: pops the next instruction. It goes to ST_SYNC on a sync, to ST_DRAIN on a halt, and to ST_ISSUE for any other opcode.
- ST_ISSUE: drives one command per accepted handshake. It returns to ST_FETCH when the last repetition is accepted.
- ST_SYNC: returns to ST_FETCH once all units are idle.
- ST_DRAIN: moves to ST_HALTED once all units are idle.
- ST_HALTED: is left only by reset.

Top module: `tensor_seq`

## Requirements
- R1: An instruction arrives as three 32-bit words, the first word carrying bits 31:0. The bit fields are:
  - op: bits 3:0
  - flags: bits 11:4
  - repeat: bits 23:12
  - length: bits 55:24
  - accumulator address: bits 71:56
  - buffer address: bits 95:72

  word_ready is low while the instruction buffer (4 entries, plus the decode register) is full.
- R2: Instructions issue strictly in push order. Every command carries the instruction's fields on cmd_ub_addr, cmd_acc_addr, cmd_len and cmd_flags.
- R3: A repeat value r produces exactly r+1 accepted commands to the target unit.
- R4: Op 0x2 (read weights) issues to the weight loader and retires on the handshake alone. wl_valid stays low while four tiles are staged.
- R5: Op 0x3 (matrix) asserts mm_valid only when a tile is staged, wt_avail is high and ifmap_avail is high. Each accepted matrix command removes one staged tile.
- R6: Instructions after an accepted matrix command issue while mm_idle is low.
- R7: Op 0x6 (sync) blocks all further issue until dma_idle, wl_idle, mm_idle and actv_idle are all high.
- R8: After op 0xF (halt) is decoded, word_ready stays low until reset. halted rises only after all idle inputs are high, and it then stays high.
- R9: An opcode outside {0x0, 0x1, 0x2, 0x3, 0x4, 0x5, 0x6, 0xF} issues no command, behaves as a nop, and sets bad_op, which stays set until reset.
- R10: Op 0x1 (read host) and op 0x5 (write host) issue on the dma port, with dma_to_host 0 and 1 respectively. The fields hold stable while dma_valid waits for dma_ready.
- R11: Op 0x4 (activate) issues on the actv port, with the function select carried on cmd_flags.
- R12: After reset, word_ready is 1, every command valid is 0, and halted and bad_op are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Host instruction word valid |
| word_data | input | 32 | Host instruction word |
| word_ready | output | 1 | Word accepted this cycle when high with word_valid |
| dma_valid | output | 1 | Host-transfer command valid |
| dma_ready | input | 1 | Host-transfer engine accepts |
| dma_to_host | output | 1 | 1 = write to host, 0 = read from host |
| wl_valid | output | 1 | Weight-read command valid |
| wl_ready | input | 1 | Weight loader accepts |
| mm_valid | output | 1 | Matrix command valid |
| mm_ready | input | 1 | Matrix unit accepts |
| actv_valid | output | 1 | Activation command valid |
| actv_ready | input | 1 | Activation stage accepts |
| cmd_ub_addr | output | 24 | Shared field: buffer address |
| cmd_acc_addr | output | 16 | Shared field: accumulator address |
| cmd_len | output | 32 | Shared field: length or weight address |
| cmd_flags | output | 8 | Shared field: flags or function select |
| wt_avail | input | 1 | Oldest staged weight tile has arrived |
| ifmap_avail | input | 1 | Input activations ready |
| dma_idle | input | 1 | Host-transfer engine idle |
| wl_idle | input | 1 | Weight loader idle |
| mm_idle | input | 1 | Matrix unit idle |
| actv_idle | input | 1 | Activation stage idle |
| halted | output | 1 | Halt reached and all units idle |
| bad_op | output | 1 | Sticky unknown-opcode flag |

## Verification
The bench sweeps the repeat count from 0 to 5 and checks every unknown opcode from 0x7 to 0xE. A miscounted repeat shows up as one command too many or too few, and a mis-decoded opcode shows up as a stray command or a missing error flag.

It fills the tile count, starves the matrix unit of each readiness input in turn, and backs up the instruction buffer. A design with a wrong tile bound would issue a fifth weight read. A design with a wrong gate would issue a matrix command without data. A design with a wrong full check would drop words.

Overlap and sync are tested while the matrix unit is held busy. A design that serialised on the matrix unit would stall the activate that follows it, and a weak sync would let a command slip through. Halt is tested while a transfer is still busy, to catch a halted flag raised too early or pushes still accepted after halt.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
    localparam int WORD_W         = 32;
    localparam int WORDS_PER_INSN = 3;
    localparam int INSN_W         = WORD_W * WORDS_PER_INSN;
    localparam int OP_W           = 4;
    localparam int FLG_W          = 8;
    localparam int REP_W          = 12;
    localparam int LEN_W          = 32;
    localparam int ACC_W          = 16;
    localparam int UB_W           = 24;

    localparam logic [OP_W-1:0] OPC_NOP    = 4'h0;
    localparam logic [OP_W-1:0] OPC_RDHOST = 4'h1;
    localparam logic [OP_W-1:0] OPC_RDWT   = 4'h2;
    localparam logic [OP_W-1:0] OPC_MATMUL = 4'h3;
    localparam logic [OP_W-1:0] OPC_ACT    = 4'h4;
    localparam logic [OP_W-1:0] OPC_WRHOST = 4'h5;
    localparam logic [OP_W-1:0] OPC_SYNC   = 4'h6;
    localparam logic [OP_W-1:0] OPC_HALT   = 4'hF;

    // Field layout, most significant first; op sits in bits 3:0 of word 0.
    typedef struct packed {
        logic [UB_W-1:0]  ub;
        logic [ACC_W-1:0] acc;
        logic [LEN_W-1:0] len;
        logic [REP_W-1:0] rep;
        logic [FLG_W-1:0] flags;
        logic [OP_W-1:0]  op;
    } insn_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_ISSUE,
        ST_SYNC,
        ST_DRAIN,
        ST_HALTED
    } seq_state_e;

    function automatic logic opc_known(input logic [OP_W-1:0] op);
        return (op == OPC_NOP)    || (op == OPC_RDHOST) || (op == OPC_RDWT) ||
               (op == OPC_MATMUL) || (op == OPC_ACT)    || (op == OPC_WRHOST) ||
               (op == OPC_SYNC)   || (op == OPC_HALT);
    endfunction
endpackage

// File: rtl/tseq_pack.sv
module tseq_pack
    import tseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic              accept_en,
    input  logic              buf_full,
    output logic              insn_we,
    output logic [INSN_W-1:0] insn_data
);
    localparam int BEAT_W = $clog2(WORDS_PER_INSN);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS_PER_INSN - 1);

    logic [BEAT_W-1:0] beat;
    logic [WORD_W-1:0] hold [WORDS_PER_INSN-1];
    logic              take;

    assign word_ready = accept_en && !buf_full;
    assign take       = word_valid && word_ready;
    assign insn_we    = take && (beat == LAST_BEAT);

    always_comb begin
        insn_data = '0;
        for (int i = 0; i < WORDS_PER_INSN - 1; i++) begin
            insn_data[i*WORD_W +: WORD_W] = hold[i];
        end
        insn_data[(WORDS_PER_INSN-1)*WORD_W +: WORD_W] = word_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (take) begin
            if (beat == LAST_BEAT) begin
                beat <= '0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < WORDS_PER_INSN - 1; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold[g] <= '0;
            end else if (take && (beat == BEAT_W'(g))) begin
                hold[g] <= word_data;
            end
        end
    end
endmodule

// File: rtl/tseq_fifo.sv
module tseq_fifo #(
    parameter int WIDTH = 96,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;

    assign full  = (cnt == CNT_FULL);
    assign empty = (cnt == '0);
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (we && !full) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (we && !full) begin
                wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
            end
            if (re && !empty) begin
                rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
            end
            unique case ({we && !full, re && !empty})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/tseq_issue.sv
module tseq_issue
    import tseq_pkg::*;
#(
    parameter int TILE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_empty,
    input  logic [INSN_W-1:0] buf_data,
    output logic              buf_pop,
    output logic              accept_en,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic              dma_to_host,
    output logic              wl_valid,
    input  logic              wl_ready,
    output logic              mm_valid,
    input  logic              mm_ready,
    output logic              actv_valid,
    input  logic              actv_ready,
    output logic [UB_W-1:0]   cmd_ub_addr,
    output logic [ACC_W-1:0]  cmd_acc_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [FLG_W-1:0]  cmd_flags,
    input  logic              wt_avail,
    input  logic              ifmap_avail,
    input  logic              dma_idle,
    input  logic              wl_idle,
    input  logic              mm_idle,
    input  logic              actv_idle,
    output logic              halted,
    output logic              bad_op
);
    localparam int TCNT_W = $clog2(TILE_DEPTH + 1);
    localparam logic [TCNT_W-1:0] TILE_FULL = TCNT_W'(TILE_DEPTH);

    seq_state_e       state, state_nx;
    insn_t            cur, nxt_insn;
    logic [REP_W-1:0] rep_left;
    logic [TCNT_W-1:0] tiles;
    logic             bad_q;
    logic             idle_all;
    logic             fire;

    assign nxt_insn = insn_t'(buf_data);
    assign idle_all = dma_idle && wl_idle && mm_idle && actv_idle;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH: begin
                if (!buf_empty) begin
                    if (nxt_insn.op == OPC_SYNC) begin
                        state_nx = ST_SYNC;
                    end else if (nxt_insn.op == OPC_HALT) begin
                        state_nx = ST_DRAIN;
                    end else begin
                        state_nx = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (fire && (rep_left == '0)) begin
                    state_nx = ST_FETCH;
                end
            end
            ST_SYNC: begin
                if (idle_all) begin
                    state_nx = ST_FETCH;
                end
            end
            ST_DRAIN: begin
                if (idle_all) begin
                    state_nx = ST_HALTED;
                end
            end
            ST_HALTED: state_nx = ST_HALTED;
            default:   state_nx = ST_FETCH;
        endcase
    end

    // Outputs
    always_comb begin
        dma_valid  = 1'b0;
        wl_valid   = 1'b0;
        mm_valid   = 1'b0;
        actv_valid = 1'b0;
        fire       = 1'b0;
        if (state == ST_ISSUE) begin
            unique case (cur.op)
                OPC_RDHOST, OPC_WRHOST: begin
                    dma_valid = 1'b1;
                    fire      = dma_ready;
                end
                OPC_RDWT: begin
                    wl_valid = (tiles != TILE_FULL);
                    fire     = wl_valid && wl_ready;
                end
                OPC_MATMUL: begin
                    mm_valid = (tiles != '0) && wt_avail && ifmap_avail;
                    fire     = mm_valid && mm_ready;
                end
                OPC_ACT: begin
                    actv_valid = 1'b1;
                    fire       = actv_ready;
                end
                default: fire = 1'b1;
            endcase
        end
        buf_pop      = (state == ST_FETCH) && !buf_empty;
        accept_en    = (state != ST_DRAIN) && (state != ST_HALTED);
        halted       = (state == ST_HALTED);
        bad_op       = bad_q;
        dma_to_host  = (cur.op == OPC_WRHOST);
        cmd_ub_addr  = cur.ub;
        cmd_acc_addr = cur.acc;
        cmd_len      = cur.len;
        cmd_flags    = cur.flags;
    end

    // Decode register, repeat counter, staged tile count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= '0;
            rep_left <= '0;
            tiles    <= '0;
            bad_q    <= 1'b0;
        end else begin
            if (buf_pop) begin
                cur      <= nxt_insn;
                rep_left <= nxt_insn.rep;
                if (!opc_known(nxt_insn.op)) begin
                    bad_q <= 1'b1;
                end
            end else if ((state == ST_ISSUE) && fire && (rep_left != '0)) begin
                rep_left <= rep_left - 1'b1;
            end
            if (wl_valid && wl_ready) begin
                tiles <= tiles + 1'b1;
            end else if (mm_valid && mm_ready) begin
                tiles <= tiles - 1'b1;
            end
        end
    end

    // R4
    tile_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tiles <= TILE_FULL);

    // R5
    mm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mm_valid |-> (wt_avail && ifmap_avail));

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(idle_all));

    // R10
    hold_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(cmd_ub_addr) && $stable(cmd_len)));
endmodule

// File: rtl/tensor_seq.sv
module tensor_seq
    import tseq_pkg::*;
#(
    parameter int BUF_DEPTH  = 4,
    parameter int TILE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic              dma_to_host,
    output logic              wl_valid,
    input  logic              wl_ready,
    output logic              mm_valid,
    input  logic              mm_ready,
    output logic              actv_valid,
    input  logic              actv_ready,
    output logic [UB_W-1:0]   cmd_ub_addr,
    output logic [ACC_W-1:0]  cmd_acc_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [FLG_W-1:0]  cmd_flags,
    input  logic              wt_avail,
    input  logic              ifmap_avail,
    input  logic              dma_idle,
    input  logic              wl_idle,
    input  logic              mm_idle,
    input  logic              actv_idle,
    output logic              halted,
    output logic              bad_op
);
    logic              accept_en;
    logic              buf_full, buf_empty, buf_pop, insn_we;
    logic [INSN_W-1:0] insn_data, buf_data;

    tseq_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_valid(word_valid),
        .word_data (word_data),
        .word_ready(word_ready),
        .accept_en (accept_en),
        .buf_full  (buf_full),
        .insn_we   (insn_we),
        .insn_data (insn_data)
    );

    tseq_fifo #(.WIDTH(INSN_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (insn_we),
        .wdata(insn_data),
        .re   (buf_pop),
        .rdata(buf_data),
        .full (buf_full),
        .empty(buf_empty)
    );

    tseq_issue #(.TILE_DEPTH(TILE_DEPTH)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_empty   (buf_empty),
        .buf_data    (buf_data),
        .buf_pop     (buf_pop),
        .accept_en   (accept_en),
        .dma_valid   (dma_valid),
        .dma_ready   (dma_ready),
        .dma_to_host (dma_to_host),
        .wl_valid    (wl_valid),
        .wl_ready    (wl_ready),
        .mm_valid    (mm_valid),
        .mm_ready    (mm_ready),
        .actv_valid  (actv_valid),
        .actv_ready  (actv_ready),
        .cmd_ub_addr (cmd_ub_addr),
        .cmd_acc_addr(cmd_acc_addr),
        .cmd_len     (cmd_len),
        .cmd_flags   (cmd_flags),
        .wt_avail    (wt_avail),
        .ifmap_avail (ifmap_avail),
        .dma_idle    (dma_idle),
        .wl_idle     (wl_idle),
        .mm_idle     (mm_idle),
        .actv_idle   (actv_idle),
        .halted      (halted),
        .bad_op      (bad_op)
    );

    // R8
    no_push_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !word_ready);
endmodule

// File: tb/tb_tensor_seq.sv
`timescale 1ns/1ps
module tb_tensor_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        dma_valid, dma_to_host, wl_valid, mm_valid, actv_valid;
    logic        dma_ready = 1'b1, wl_ready = 1'b1, mm_ready = 1'b1, actv_ready = 1'b1;
    logic [23:0] cmd_ub_addr;
    logic [15:0] cmd_acc_addr;
    logic [31:0] cmd_len;
    logic [7:0]  cmd_flags;
    logic        wt_avail = 1'b1, ifmap_avail = 1'b1;
    logic        dma_idle = 1'b1, wl_idle = 1'b1, mm_idle = 1'b1, actv_idle = 1'b1;
    logic        halted, bad_op;

    int n_chk = 0, n_fail = 0;
    int n_dma = 0, n_wl = 0, n_mm = 0, n_act = 0;
    int seq_n = 0;
    int seq_log [256];
    logic        last_to_host = 1'b0;
    logic [23:0] last_ub = '0;
    logic [15:0] last_acc = '0;
    logic [31:0] last_len = '0;
    logic [7:0]  last_flags = '0;

    always #2.5 clk = ~clk;

    tensor_seq dut (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_to_host(dma_to_host),
        .wl_valid(wl_valid), .wl_ready(wl_ready),
        .mm_valid(mm_valid), .mm_ready(mm_ready),
        .actv_valid(actv_valid), .actv_ready(actv_ready),
        .cmd_ub_addr(cmd_ub_addr), .cmd_acc_addr(cmd_acc_addr),
        .cmd_len(cmd_len), .cmd_flags(cmd_flags),
        .wt_avail(wt_avail), .ifmap_avail(ifmap_avail),
        .dma_idle(dma_idle), .wl_idle(wl_idle), .mm_idle(mm_idle), .actv_idle(actv_idle),
        .halted(halted), .bad_op(bad_op)
    );

    // Handshake monitor, sampled 1 ns after the falling edge.
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (dma_valid && dma_ready) begin n_dma++; last_to_host = dma_to_host; log_unit(1); end
            if (wl_valid && wl_ready)   begin n_wl++;  log_unit(2); end
            if (mm_valid && mm_ready)   begin n_mm++;  log_unit(3); end
            if (actv_valid && actv_ready) begin n_act++; log_unit(4); end
        end
    end

    task automatic log_unit(input int u);
        if (seq_n < 256) seq_log[seq_n] = u;
        seq_n++;
        last_ub = cmd_ub_addr; last_acc = cmd_acc_addr;
        last_len = cmd_len; last_flags = cmd_flags;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] mk(input logic [3:0] op, input logic [7:0] flg,
                                       input logic [11:0] rep, input logic [31:0] len,
                                       input logic [15:0] acc, input logic [23:0] ub);
        return {ub, acc, len, rep, flg, op};
    endfunction

    task automatic push_word(input logic [31:0] w);
        word_data = w;
        word_valid = 1'b1;
        while (!word_ready) @(negedge clk);
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic push_insn(input logic [95:0] ins);
        for (int i = 0; i < 3; i++) push_word(ins[i*32 +: 32]);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        word_valid = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    int base, base_other;

    initial begin
        wait_cyc(2);
        do_reset();
        // R12 reset state
        check("R12 word_ready", word_ready, 1);
        check("R12 valids", {dma_valid, wl_valid, mm_valid, actv_valid}, 0);
        check("R12 halted/bad_op", {halted, bad_op}, 0);

        // R10 / R2: host read then host write, fields and order
        base = seq_n;
        push_insn(mk(4'h1, 8'h00, 12'd0, 32'h0000_0040, 16'h0000, 24'h123456));
        push_insn(mk(4'h5, 8'h00, 12'd0, 32'h0000_0080, 16'h0000, 24'h654321));
        wait_cyc(4);
        check("R10 dma count", n_dma, 2);
        check("R10 write-host direction", last_to_host, 1);
        check("R2 dma ub field", last_ub, 24'h654321);
        check("R2 dma len field", last_len, 32'h80);

        // R3 / R11: repeat sweep on activate
        for (int r = 0; r < 6; r++) begin
            base = n_act;
            push_insn(mk(4'h4, 8'(r * 17 + 3), 12'(r), 32'h0, 16'(16'h0100 + r), 24'h000010));
            wait_cyc(10 + r);
            check("R3 repeat count", n_act - base, r + 1);
            check("R11 function select", last_flags, r * 17 + 3);
            check("R2 acc field", last_acc, 16'h0100 + r);
        end

        // R1: buffer fills while activation stage is stalled
        actv_ready = 1'b0;
        base = n_act;
        for (int k = 0; k < 5; k++) push_insn(mk(4'h4, 8'(k), 12'd0, 32'h0, 16'h0, 24'h0));
        check("R1 word_ready low when full", word_ready, 0);
        actv_ready = 1'b1;
        wait_cyc(20);
        check("R1 all buffered issued", n_act - base, 5);
        check("R1 word_ready restored", word_ready, 1);

        // R6: overlap with busy matrix unit
        mm_idle = 1'b0;
        base = seq_n;
        push_insn(mk(4'h2, 8'h00, 12'd0, 32'h0000_1000, 16'h0, 24'h0));
        push_insn(mk(4'h3, 8'h01, 12'd0, 32'h0000_0100, 16'h0020, 24'h000200));
        push_insn(mk(4'h4, 8'h33, 12'd0, 32'h0, 16'h0020, 24'h000300));
        wait_cyc(10);
        check("R6 activate issued while matrix busy", seq_n - base, 3);
        check("R2 order wl,mm,act", {seq_log[base], seq_log[base+1], seq_log[base+2]}, {32'd2, 32'd3, 32'd4});

        // R7: sync holds issue until all idle
        base = n_act;
        push_insn(mk(4'h6, 8'h00, 12'd0, 32'h0, 16'h0, 24'h0));
        push_insn(mk(4'h4, 8'h44, 12'd0, 32'h0, 16'h0, 24'h0));
        wait_cyc(20);
        check("R7 no issue during sync", n_act - base, 0);
        mm_idle = 1'b1;
        wait_cyc(8);
        check("R7 issue after idle", n_act - base, 1);
        check("R7 following fields", last_flags, 8'h44);

        // R9: unknown opcodes 0x7..0xE
        for (int c = 7; c < 15; c++) begin
            base = n_act;
            base_other = n_dma + n_wl + n_mm;
            push_insn(mk(4'(c), 8'hFF, 12'd2, 32'hFFFF, 16'hFFFF, 24'hFFFF));
            push_insn(mk(4'h4, 8'h55, 12'd0, 32'h0, 16'h0, 24'h0));
            wait_cyc(12);
            check("R9 no stray command", n_dma + n_wl + n_mm - base_other, 0);
            check("R9 next instruction runs", n_act - base, 1);
            check("R9 bad_op set", bad_op, 1);
        end

        // R4: tile bound
        do_reset();
        check("R9 bad_op cleared by reset", bad_op, 0);
        base = n_wl;
        push_insn(mk(4'h2, 8'h00, 12'd4, 32'h0000_ABCD, 16'h0, 24'h0));
        wait_cyc(30);
        check("R4 four reads then block", n_wl - base, 4);
        check("R4 wl_valid low when full", wl_valid, 0);
        check("R4 weight address field", last_len, 32'hABCD);

        // R5: matrix gating
        do_reset();
        wt_avail = 1'b0;
        base = n_mm;
        push_insn(mk(4'h2, 8'h00, 12'd1, 32'h0, 16'h0, 24'h0));
        push_insn(mk(4'h3, 8'h01, 12'd2, 32'h0000_0100, 16'h0042, 24'h000800));
        wait_cyc(20);
        check("R5 held without weights", n_mm - base, 0);
        wt_avail = 1'b1;
        ifmap_avail = 1'b0;
        wait_cyc(10);
        check("R5 held without activations", n_mm - base, 0);
        ifmap_avail = 1'b1;
        wait_cyc(10);
        check("R5 one tile per issue", n_mm - base, 2);
        check("R5 no issue with no tile", mm_valid, 0);
        check("R5 acc field", last_acc, 16'h0042);

        // R8: halt waits for idle and locks the push port
        do_reset();
        dma_idle = 1'b0;
        push_insn(mk(4'h1, 8'h00, 12'd0, 32'h10, 16'h0, 24'h000001));
        push_insn(mk(4'hF, 8'h00, 12'd0, 32'h0, 16'h0, 24'h0));
        wait_cyc(10);
        check("R8 not halted while busy", halted, 0);
        check("R8 push locked after halt", word_ready, 0);
        dma_idle = 1'b1;
        wait_cyc(4);
        check("R8 halted after idle", halted, 1);
        wait_cyc(10);
        check("R8 halted stays", halted, 1);
        check("R8 push still locked", word_ready, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule